// File: doc/BRIEF.md
# Two-Way Set-Associative Tag Cache with Most-Recent Victim Replacement

This block is the tag side of a two-way set-associative cache. Each request carries an address. The block reports whether that address hits, which way served it or received it, and a running miss count that an observer can sample. Only tags and valid bits are stored, because hit and miss behaviour is all that matters here. There is no data array, no write policy and no line offset.

Replacement works in an unusual way. When a miss lands in a set whose two ways are both occupied, the way evicted is the one touched most recently, not the oldest one. An empty way is always filled first. As a result, a line that the access stream no longer touches can stay resident for good, while two addresses that alternate in the same set keep evicting each other.

Each set keeps one most-recent marker. Each way keeps a valid bit and a tag. The lookup is combinational against the state at the request edge, and its result is registered, so the response appears one cycle after the request.

Top module: `mru_victim_cache`

## Requirements
- R1: After reset, every way of every set is invalid, `miss_count` is zero and `rsp_valid` is low. An address that was resident before the reset misses on its first access after it.
- R2: The set index is `req_addr[SET_BITS-1:0]`. The tag is the remaining upper bits `req_addr[ADDR_W-1:SET_BITS]`. With the default parameters (16-bit address, 3 index bits), address = tag*8 + set.
- R3: A request accepted on a rising edge (`req_valid` high) produces `rsp_valid` high, plus its `rsp_hit` and `rsp_way`, in the cycle after that edge. With no request, `rsp_valid` is low in the following cycle.
- R4: A request hits (`rsp_hit`=1) exactly when a valid way of its set holds its tag. `rsp_way` then gives that way (0 or 1), and the set contents are left unchanged.
- R5: A miss into a set with an empty way installs the tag into an empty way, and nothing is evicted. Way 0 is filled before way 1.
- R6: A miss into a set whose two ways are both valid replaces the way that was accessed most recently. `rsp_way` gives the replaced way.
- R7: Every accepted request, hit or miss, makes the way it used the most recently accessed way of its set.
- R8: `miss_count` (CNT_W bits) goes up by one on every miss. It holds on hits and idle cycles, and it saturates at all ones.
- R9: Sets are independent. Accesses to one set never change the contents or the most-recent marker of another set.
- R10: Cycles with `req_valid` low change no cache state and do not change `miss_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one lookup per cycle |
| req_addr | input | ADDR_W | Request address (tag and set index) |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | 1 | Way that hit or was filled |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
The bench loads a set with a recent line and an older line, then alternates two addresses into it. It expects every access to miss into the same way while the older line survives and then hits. A design that evicts the oldest line, or that fails to update the recency marker on hits, would evict that older line and report a hit where a miss is expected. A second set is given only one line so the alternating pair settles into steady hits. This catches a design that evicts while an empty way remains, or that fills way 1 first. A run of several hundred distinct misses checks that the counter sticks at all ones and does not wrap. A mid-run reset checks that lines resident before it are really forgotten, and idle cycles check that the counter does not drift.

// File: rtl/mvc_pkg.sv
package mvc_pkg;
   localparam int unsigned MVC_WAYS = 2;
   typedef logic mvc_way_t;
endpackage

// File: rtl/mvc_tag_way.sv
module mvc_tag_way #(
   parameter int unsigned SETS  = 8,
   parameter int unsigned TAG_W = 13,
   localparam int unsigned IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) valid_q <= '0;
      else if (wr_en) valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_idx] <= wr_tag;
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];

   // a written entry is valid and holds the written tag on the next cycle
   p_fill_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag)));
   // without a write, the valid vector is unchanged
   p_valid_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/mvc_recency.sv
module mvc_recency #(
   parameter int unsigned SETS = 8,
   localparam int unsigned IDX_W = $clog2(SETS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IDX_W-1:0]     rd_idx,
   output mvc_pkg::mvc_way_t    rd_mru,
   input  logic                 upd,
   input  logic [IDX_W-1:0]     upd_idx,
   input  mvc_pkg::mvc_way_t    upd_way
);
   logic [SETS-1:0] mru_q;

   always_ff @(posedge clk) begin
      if (!rst_n) mru_q <= '0;
      else if (upd) mru_q[upd_idx] <= upd_way;
   end

   assign rd_mru = mru_q[rd_idx];

   p_mru_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> mru_q[$past(upd_idx)] == $past(upd_way));
   p_mru_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(mru_q));
endmodule

// File: rtl/mvc_miss_ctr.sv
module mvc_miss_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = '1;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (inc && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
   p_count_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == TOP) |=> cnt_q == TOP);
   p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt_q));
endmodule

// File: rtl/mru_victim_cache.sv
module mru_victim_cache #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned SET_BITS = 3,
   parameter int unsigned CNT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_way,
   output logic [CNT_W-1:0]  miss_count
);
   import mvc_pkg::*;

   localparam int unsigned SETS  = 1 << SET_BITS;
   localparam int unsigned TAG_W = ADDR_W - SET_BITS;

   initial begin
      assert (SET_BITS >= 1 && SET_BITS < ADDR_W) else $error("SET_BITS out of range");
      assert (CNT_W >= 1) else $error("CNT_W must be positive");
   end

   // R2: address split
   logic [SET_BITS-1:0] idx;
   logic [TAG_W-1:0]    tag;
   assign idx = req_addr[SET_BITS-1:0];
   assign tag = req_addr[ADDR_W-1:SET_BITS];

   logic [MVC_WAYS-1:0] way_valid;
   logic [MVC_WAYS-1:0] way_match;
   logic [MVC_WAYS-1:0] way_fill;
   mvc_way_t            mru_way;
   mvc_way_t            victim;
   mvc_way_t            use_way;
   logic                hit_c;

   for (genvar w = 0; w < MVC_WAYS; w++) begin : g_way
      logic [TAG_W-1:0] rd_tag;
      mvc_tag_way #(.SETS(SETS), .TAG_W(TAG_W)) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (idx),
         .rd_valid (way_valid[w]),
         .rd_tag   (rd_tag),
         .wr_en    (way_fill[w]),
         .wr_idx   (idx),
         .wr_tag   (tag)
      );
      assign way_match[w] = way_valid[w] && (rd_tag == tag);
      assign way_fill[w]  = req_valid && !hit_c && (victim == mvc_way_t'(w));
   end

   assign hit_c = |way_match;

   // R5/R6: empty way first (way 0 before way 1), else the most recent way
   always_comb begin
      if (!way_valid[0])      victim = 1'b0;
      else if (!way_valid[1]) victim = 1'b1;
      else                    victim = mru_way;
   end

   assign use_way = hit_c ? way_match[1] : victim;

   mvc_recency #(.SETS(SETS)) u_rec (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (idx),
      .rd_mru  (mru_way),
      .upd     (req_valid),
      .upd_idx (idx),
      .upd_way (use_way)
   );

   mvc_miss_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (req_valid && !hit_c),
      .count (miss_count)
   );

   // R3: registered response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_way   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && hit_c;
         rsp_way   <= req_valid ? use_way : 1'b0;
      end
   end

   p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_rsp_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_hit);
   p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_match));
   p_empty_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit_c && !way_valid[0]) |=> !rsp_hit && rsp_way == 1'b0);
   p_mru_victim_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit_c && (&way_valid)) |=> rsp_way == $past(mru_way));
endmodule

// File: tb/sim_mru_victim_cache.sv
module sim_mru_victim_cache;
   localparam int ADDR_W = 16;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              rsp_valid, rsp_hit, rsp_way;
   logic [CNT_W-1:0]  miss_count;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   mru_victim_cache #(.ADDR_W(ADDR_W), .SET_BITS(3), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
      .miss_count(miss_count)
   );

   // {expected hit, expected way, address}; address = tag*8 + set
   localparam int NV = 16;
   localparam logic [17:0] VEC [NV] = '{
      {1'b0, 1'b0, 16'h0000},  // tag 0 set 0 after reset: miss, R1/R5
      {1'b0, 1'b0, 16'h0029},  // a set1 -> way0 (R5)
      {1'b0, 1'b1, 16'h0049},  // c set1 -> way1 (R5)
      {1'b1, 1'b0, 16'h0029},  // a hits, becomes most recent (R4/R7)
      {1'b0, 1'b0, 16'h0039},  // b evicts most recent a (R6)
      {1'b0, 1'b0, 16'h0029},  // a evicts b (R6)
      {1'b0, 1'b0, 16'h0039},  // b evicts a (R6)
      {1'b0, 1'b0, 16'h0029},  // a evicts b (R6)
      {1'b1, 1'b1, 16'h0049},  // c never evicted (R6)
      {1'b0, 1'b0, 16'h002A},  // a set2 -> way0
      {1'b0, 1'b1, 16'h003A},  // b set2 -> empty way1, no eviction (R5)
      {1'b1, 1'b0, 16'h002A},  // steady hits (R4)
      {1'b1, 1'b1, 16'h003A},
      {1'b1, 1'b0, 16'h002A},
      {1'b1, 1'b1, 16'h003A},
      {1'b1, 1'b0, 16'h0029}   // set1 untouched by set2 (R9)
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // call at a negedge; returns at the next negedge with the response visible
   task automatic access(input logic [ADDR_W-1:0] a);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int exp_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 rsp_valid after reset", int'(rsp_valid), 0);
      check("R1 miss_count after reset", int'(miss_count), 0);

      exp_cnt = 0;
      for (int i = 0; i < NV; i++) begin
         access(VEC[i][15:0]);
         if (!VEC[i][17]) exp_cnt++;
         check("R3 rsp_valid one cycle after request", int'(rsp_valid), 1);
         check("R4/R5/R6 hit", int'(rsp_hit), int'(VEC[i][17]));
         check("R4/R5/R6/R7 way", int'(rsp_way), int'(VEC[i][16]));
         check("R8 miss_count", int'(miss_count), exp_cnt);
      end

      // R10: idle cycles change nothing
      repeat (4) @(negedge clk);
      check("R3 rsp_valid low when idle", int'(rsp_valid), 0);
      check("R10 miss_count stable when idle", int'(miss_count), exp_cnt);
      access(16'h0049);
      check("R10 state kept over idle (c hit)", int'(rsp_hit), 1);
      check("R10 state kept over idle (c way)", int'(rsp_way), 1);
      check("R8 hit holds count", int'(miss_count), exp_cnt);

      // R1: reset mid-run forgets resident lines
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 count cleared", int'(miss_count), 0);
      check("R1 rsp_valid cleared", int'(rsp_valid), 0);
      access(16'h0049);
      check("R1 resident line lost", int'(rsp_hit), 0);
      check("R1 refill way0", int'(rsp_way), 0);
      check("R8 first miss after reset", int'(miss_count), 1);

      // R8 saturation: 300 distinct tags in set 3
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int t = 1; t <= 300; t++) begin
         access(ADDR_W'((t << 3) | 3));
         if (rsp_hit) check("R6 distinct tags miss", 1, 0);
      end
      check("R8 saturated count", int'(miss_count), 255);
      access(ADDR_W'((300 << 3) | 3));
      check("R6 last fill in most-recent way1 hits", int'(rsp_hit), 1);
      check("R6 last fill way", int'(rsp_way), 1);
      check("R8 stays saturated", int'(miss_count), 255);
      access(ADDR_W'((1 << 3) | 3));
      check("R6 first line survives in way0", int'(rsp_hit), 1);
      check("R6 first line way", int'(rsp_way), 0);

      summary();
      $finish;
   end
endmodule